// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator

This block gathers event conditions into two sticky event words, a low word and a high word. Each word has its own mask word, and a two-bit summary mask enables or disables each word's contribution as a whole. The block drives a single active-high interrupt line. It goes high one cycle after any event bit is set whose mask bit is set, provided that the summary bit for that word is also set.

A host reaches the block through a plain register-write port: a write strobe, a 3-bit register select and a data word. This port sits behind a serial slave front end, which also supplies a level that stays high for as long as its serial transaction is open. A write to either event word clears every event bit for which the data holds a 1. That write also blanks the interrupt line. The blanking holds until the front end reports that the transaction has closed, so the host never sees an interrupt edge in the middle of its own acknowledge sequence.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, both event words, both mask words and the summary mask are zero, and `irq_o` is low.
- R2: A one-cycle high level on bit b of `set_lo_i` or `set_hi_i` sets bit b of the matching event word at the next clock edge. The bit stays set until the host clears it.
- R3: A write to select 0 (low event word) or select 1 (high event word) clears each bit where the data bit is 1. Bits whose data bit is 0 keep their value.
- R4: When a set pulse and a clearing write hit the same event bit in the same cycle, the bit ends up set.
- R5: Select 2 writes the low mask word and select 3 writes the high mask word. Select 4 writes the summary mask from data bits [1:0]: bit 0 enables the low word and bit 1 enables the high word.
- R6: `irq_o` equals the value registered one clock after the event and mask state: (OR of low events AND low mask, gated by summary bit 0) OR (OR of high events AND high mask, gated by summary bit 1).
- R7: After a write to select 0 or 1, `irq_o` is low from the next edge onward. It stays low until the first edge at which `xact_active_i` is sampled low with no further event-word write. At that edge `irq_o` again follows R6.
- R8: Writes to selects 2, 3 and 4 do not blank `irq_o`.
- R9: Writes to selects 5, 6 and 7 change no event, mask or summary state, and do not blank `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| set_lo_i | input | EVW | Set pulses for the low event word |
| set_hi_i | input | EVW | Set pulses for the high event word |
| xact_active_i | input | 1 | High while the serial transaction is open |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select |
| wr_data_i | input | EVW | Write data |
| irq_o | output | 1 | Interrupt, active high |
| evt_lo_o | output | EVW | Current low event word |
| evt_hi_o | output | EVW | Current high event word |

## Verification
The bench builds the block with EVW = 4. At that width every low-word event pattern can be swept against every low mask and every summary mask value, and the same sweep is repeated for the high word. That is 1024 combinations per word, each with its interrupt level worked out arithmetically. The small width also keeps the sticky-clear sweeps, the set-versus-clear collision and the blanking window short enough to check cycle by cycle. The blanking window is checked while a transaction is held open, on the cycle the transaction closes, and against writes to configuration and unused selects.

// File: rtl/irqagg_pkg.sv
// Package: shared register-select encoding for the interrupt aggregator.
// Assumes a 3-bit select; codes 5..7 are unused and must be ignored.
package irqagg_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_EVT_LO  = 3'd0,
        SEL_EVT_HI  = 3'd1,
        SEL_MASK_LO = 3'd2,
        SEL_MASK_HI = 3'd3,
        SEL_SUMMARY = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/irqagg_evt_word.sv
// Module: one sticky event word.
// Each bit is set by a one-cycle pulse on its set line and cleared by a
// write-one-to-clear strobe. A set pulse overrides a clear on the same bit.
// Assumes: synchronous active-low reset; set lines are already synchronous.
module irqagg_evt_word #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] evt_o
);
    logic [W-1:0] evt_q;
    logic [W-1:0] clr_mask;

    // Bits that the current write asks to clear.
    assign clr_mask = clr_we_i ? clr_data_i : '0;

    for (genvar b = 0; b < W; b++) begin : g_bit
        // Sticky bit: set has priority, then write-one-to-clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          evt_q[b] <= 1'b0;
            else if (set_i[b])   evt_q[b] <= 1'b1;
            else if (clr_mask[b]) evt_q[b] <= 1'b0;
        end
    end

    assign evt_o = evt_q;

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((evt_o & $past(set_i)) == $past(set_i)));

    // R3
    no_spurious_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(evt_o) & ~evt_o & ~$past(clr_mask)) == '0));
endmodule

// File: rtl/irqagg_cfg.sv
// Module: mask and summary-mask registers.
// Holds the low and high mask words and the 2-bit summary mask. Unused
// select codes leave all state untouched.
// Assumes: W >= 2 so the summary fits in the data word.
module irqagg_cfg
    import irqagg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [W-1:0]     wr_data_i,
    output logic [W-1:0]     mask_lo_o,
    output logic [W-1:0]     mask_hi_o,
    output logic [1:0]       summary_o
);
    logic [W-1:0] mask_lo_q;
    logic [W-1:0] mask_hi_q;
    logic [1:0]   summary_q;

    // Register writes to the three configuration selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_lo_q <= '0;
            mask_hi_q <= '0;
            summary_q <= '0;
        end else if (wr_en_i) begin
            case (reg_sel_e'(wr_sel_i))
                SEL_MASK_LO: mask_lo_q <= wr_data_i;
                SEL_MASK_HI: mask_hi_q <= wr_data_i;
                SEL_SUMMARY: summary_q <= wr_data_i[1:0];
                default: ;
            endcase
        end
    end

    assign mask_lo_o = mask_lo_q;
    assign mask_hi_o = mask_hi_q;
    assign summary_o = summary_q;

    // R9
    unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i > 3'd4) |=>
        ($stable(mask_lo_o) && $stable(mask_hi_o) && $stable(summary_o)));
endmodule

// File: rtl/irqagg_blank.sv
// Module: interrupt blanking window tracker.
// Opens on any event-word write and stays open while the serial
// transaction remains active. Provides the next-state blank level so the
// interrupt register drops on the same edge as the write.
// Assumes: xact_i is synchronous to clk.
module irqagg_blank (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_wr_i,
    input  logic xact_i,
    output logic blank_nxt_o
);
    logic blank_q;

    // Window opens on an event write, persists while the transaction is open.
    assign blank_nxt_o = evt_wr_i | (blank_q & xact_i);

    // Window state register.
    always_ff @(posedge clk) begin
        if (!rst_n) blank_q <= 1'b0;
        else        blank_q <= blank_nxt_o;
    end

    // R7
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_q && xact_i) |=> blank_q);
endmodule

// File: rtl/irq_aggregator.sv
// Module: masked event interrupt aggregator (top).
// Two sticky event words, per-word masks, a summary mask and a registered
// interrupt output that is blanked across any transaction that writes an
// event word.
// Assumes: EVW >= 2; synchronous active-low reset; all inputs synchronous.
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int EVW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVW-1:0]   set_lo_i,
    input  logic [EVW-1:0]   set_hi_i,
    input  logic             xact_active_i,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [EVW-1:0]   wr_data_i,
    output logic             irq_o,
    output logic [EVW-1:0]   evt_lo_o,
    output logic [EVW-1:0]   evt_hi_o
);
    logic           wr_evt_lo;
    logic           wr_evt_hi;
    logic           evt_wr;
    logic [EVW-1:0] mask_lo;
    logic [EVW-1:0] mask_hi;
    logic [1:0]     summary;
    logic           blank_nxt;
    logic           pend_any;
    logic           irq_q;

    // Decode writes aimed at the event words.
    assign wr_evt_lo = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_EVT_LO);
    assign wr_evt_hi = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_EVT_HI);
    assign evt_wr    = wr_evt_lo | wr_evt_hi;

    irqagg_evt_word #(.W(EVW)) u_evt_lo (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_lo_i),
        .clr_we_i   (wr_evt_lo),
        .clr_data_i (wr_data_i),
        .evt_o      (evt_lo_o)
    );

    irqagg_evt_word #(.W(EVW)) u_evt_hi (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_hi_i),
        .clr_we_i   (wr_evt_hi),
        .clr_data_i (wr_data_i),
        .evt_o      (evt_hi_o)
    );

    irqagg_cfg #(.W(EVW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .mask_lo_o (mask_lo),
        .mask_hi_o (mask_hi),
        .summary_o (summary)
    );

    irqagg_blank u_blank (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_wr_i    (evt_wr),
        .xact_i      (xact_active_i),
        .blank_nxt_o (blank_nxt)
    );

    // Enabled pending condition from current event and mask state.
    assign pend_any = ((|(evt_lo_o & mask_lo)) & summary[0])
                    | ((|(evt_hi_o & mask_hi)) & summary[1]);

    // Registered interrupt, forced low inside the blanking window.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pend_any & ~blank_nxt;
    end

    assign irq_o = irq_q;

    // R7
    irq_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wr |=> !irq_o);

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(pend_any));
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
    localparam int CLK_PERIOD = 10;
    localparam int EVW = 4;
    localparam int FULL = (1 << EVW) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [EVW-1:0] set_lo = '0;
    logic [EVW-1:0] set_hi = '0;
    logic           xact = 1'b0;
    logic           wr_en = 1'b0;
    logic [2:0]     wr_sel = '0;
    logic [EVW-1:0] wr_data = '0;
    logic           irq;
    logic [EVW-1:0] evt_lo;
    logic [EVW-1:0] evt_hi;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggregator #(.EVW(EVW)) i_irq_aggregator (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_lo_i      (set_lo),
        .set_hi_i      (set_hi),
        .xact_active_i (xact),
        .wr_en_i       (wr_en),
        .wr_sel_i      (wr_sel),
        .wr_data_i     (wr_data),
        .irq_o         (irq),
        .evt_lo_o      (evt_lo),
        .evt_hi_o      (evt_hi)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive a one-cycle write; returns at the following falling edge.
    task automatic wr(input int sel, input int data);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = EVW'(data);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    endtask

    task automatic pulse(input int lo, input int hi);
        set_lo = EVW'(lo); set_hi = EVW'(hi);
        @(negedge clk);
        set_lo = '0; set_hi = '0;
    endtask

    function automatic int exp_irq(int elo, int mlo, int ehi, int mhi, int s);
        return ((((elo & mlo) != 0) && s[0]) || (((ehi & mhi) != 0) && s[1])) ? 1 : 0;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        chk("R1 evt_lo", int'(evt_lo), 0);
        chk("R1 evt_hi", int'(evt_hi), 0);
        pulse(FULL, FULL);
        @(negedge clk);
        chk("R1 masks zero keep irq low", int'(irq), 0);
        wr(0, FULL); wr(1, FULL);
        chk("R3 full clear lo", int'(evt_lo), 0);
        chk("R3 full clear hi", int'(evt_hi), 0);

        // R2 R5 R6 sweep over low word: mask x pattern x summary
        for (int m = 0; m <= FULL; m++) begin
            wr(2, m);
            for (int s = 0; s < 4; s++) begin
                wr(4, s);
                for (int p = 0; p <= FULL; p++) begin
                    pulse(p, 0);
                    chk("R2 lo set", int'(evt_lo), p);
                    @(negedge clk);
                    chk("R6 R5 lo irq", int'(irq), exp_irq(p, m, 0, 0, s));
                    wr(0, FULL);
                    chk("R3 lo clear", int'(evt_lo), 0);
                end
            end
        end
        wr(2, 0);
        // Same sweep over the high word
        for (int m = 0; m <= FULL; m++) begin
            wr(3, m);
            for (int s = 0; s < 4; s++) begin
                wr(4, s);
                for (int p = 0; p <= FULL; p++) begin
                    pulse(0, p);
                    chk("R2 hi set", int'(evt_hi), p);
                    @(negedge clk);
                    chk("R6 R5 hi irq", int'(irq), exp_irq(0, 0, p, m, s));
                    wr(1, FULL);
                    chk("R3 hi clear", int'(evt_hi), 0);
                end
            end
        end

        // R3 zeros in write data leave bits alone
        for (int p = 0; p <= FULL; p++) begin
            for (int d = 0; d <= FULL; d++) begin
                pulse(p, p);
                wr(0, d);
                chk("R3 partial lo", int'(evt_lo), p & ~d & FULL);
                wr(1, d);
                chk("R3 partial hi", int'(evt_hi), p & ~d & FULL);
                wr(0, FULL); wr(1, FULL);
            end
        end

        // R4 set beats clear on the same bit
        set_lo = 4'b0101; set_hi = 4'b0011;
        wr(0, FULL);
        set_lo = '0; set_hi = '0;
        chk("R4 lo set wins", int'(evt_lo), 5);
        set_hi = 4'b0010;
        wr(1, FULL);
        set_hi = '0;
        chk("R4 hi set wins", int'(evt_hi), 2);
        wr(0, FULL); wr(1, FULL);

        // R7 blanking window across an open transaction
        wr(2, FULL); wr(4, 1);
        pulse(1, 0);
        @(negedge clk);
        chk("R7 irq before window", int'(irq), 1);
        xact = 1'b1;
        @(negedge clk);
        wr(1, 0);
        chk("R7 irq blanked after write", int'(irq), 0);
        chk("R7 lo event still pending", int'(evt_lo), 1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R7 irq held low in transaction", int'(irq), 0);
        end
        xact = 1'b0;
        @(negedge clk);
        chk("R7 irq returns at transaction end", int'(irq), 1);

        // R8 config writes inside a transaction do not blank
        xact = 1'b1;
        wr(2, FULL);
        chk("R8 mask write no blank", int'(irq), 1);
        wr(4, 1);
        chk("R8 summary write no blank", int'(irq), 1);
        // R9 unused selects: no blank, no state change
        wr(5, 0); wr(6, 0); wr(7, 0);
        chk("R9 unused select no blank", int'(irq), 1);
        chk("R9 evt_lo untouched", int'(evt_lo), 1);
        xact = 1'b0;
        wr(7, 0); wr(5, 2);
        @(negedge clk);
        chk("R9 masks untouched", int'(irq), 1);
        pulse(0, 8);
        wr(6, FULL);
        @(negedge clk);
        chk("R9 evt_hi untouched", int'(evt_hi), 8);
        chk("R9 summary untouched", int'(irq), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule